// File: doc/BRIEF.md
# Fail-Safe Operating Mode Controller

This block sequences the operating mode of a supervisory companion chip that sits beside a microcontroller. Software writes 3-bit mode codes through a simple register-write strobe. The controller moves between Start-up, Normal, Flash and Fail-safe modes. Whenever a rule is broken, or a supervised deadline passes without a valid write, it issues a fixed-length system reset pulse. It also records a 3-bit code that tells software why the last reset happened.

Flash mode is reached through a two-step handshake in Start-up mode. The first flash request yields a reset that confirms the microcontroller restarted. Only a second request, made after that reset, enters Flash mode. In Flash mode software must keep serving a watchdog, and it leaves the mode with a dedicated exit code. A failing oscillator overrides every mode and parks the block in Fail-safe mode with the system held in reset. The block leaves Fail-safe mode only when the oscillator is healthy and a wake-up event is seen.

Top module: `failsafe_mode_ctrl`

## Requirements
- R1: After reset, `mode` is 00 (Start-up), `sys_rst` is low and `rst_src` is 000 (power-on).
- R2: Mode encoding is 00 Start-up, 01 Normal, 10 Flash, 11 Fail-safe. Code 101 in Start-up enters Normal with no reset. Code 101 in Normal has no effect.
- R3: In Start-up, code 011 with no handshake pending starts a reset with `rst_src` 001 and stays in Start-up. Code 011 with a handshake pending enters Flash with no reset. Flash is entered only from Start-up.
- R4: A pending flash handshake is cleared by code 101, by any reset event and by entering Flash, so the next 011 starts a new handshake.
- R5: In Flash, code 111 restarts the flash watchdog. FLASH_TICKS cycles without it force a reset with `rst_src` 011 and a return to Start-up.
- R6: Code 110 in Flash causes a reset with `rst_src` 100 and a return to Start-up.
- R7: Any code not allowed in the current mode causes a reset with `rst_src` 101 and a return to Start-up. The allowed codes are 011 and 101 in Start-up, 101 in Normal, and 111 and 110 in Flash.
- R8: STARTUP_TICKS cycles in Start-up with no valid write force a reset with `rst_src` 010. The block stays in Start-up.
- R9: Each reset pulse holds `sys_rst` high for exactly RST_LEN cycles. Writes made during the pulse are ignored, and `rst_src` does not change during it.
- R10: `osc_fail` high moves the block to Fail-safe on the next cycle with `rst_src` 110. `sys_rst` stays high for the whole time in Fail-safe, and writes there are ignored.
- R11: Fail-safe is left only in a cycle with `wake` high and `osc_fail` low. The block then goes to Start-up with `rst_src` 111, and `sys_rst` falls RST_LEN cycles later.
- R12: A rising edge on `sys_rst` always finds the block in Start-up or Fail-safe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | One-cycle strobe: a mode code is written |
| wr_code | input | 3 | Mode code written by software |
| osc_fail | input | 1 | Oscillator out of range or stopped |
| wake | input | 1 | Wake-up event |
| mode | output | 2 | Current operating mode |
| sys_rst | output | 1 | System reset to the microcontroller, active high |
| rst_src | output | 3 | Cause of the last reset event |

## Verification
The assertions assume that `osc_fail` and `wake` are synchronous to `clk`, and that a write strobe lasts a single cycle. They also assume that the checker sees the internally synchronised reset, so nothing fires during the two-cycle release window. The stimulus drives every input on the falling edge, one write at a time. It keeps `osc_fail` low except in the fail-safe scenario and does not raise it while a reset pulse is running. Expected reset causes are queued by the driver and matched on each rising `sys_rst` outside Fail-safe.

// File: rtl/fsmc_pkg.sv
package fsmc_pkg;

  typedef enum logic [1:0] {
    MD_STARTUP  = 2'b00,
    MD_NORMAL   = 2'b01,
    MD_FLASH    = 2'b10,
    MD_FAILSAFE = 2'b11
  } mode_e;

  typedef enum logic [2:0] {
    SRC_POWERON    = 3'd0,
    SRC_HANDSHAKE  = 3'd1,
    SRC_INIT_TMO   = 3'd2,
    SRC_FLASH_TMO  = 3'd3,
    SRC_FLASH_EXIT = 3'd4,
    SRC_ILLEGAL    = 3'd5,
    SRC_OSC        = 3'd6,
    SRC_WAKE       = 3'd7
  } src_e;

  localparam logic [2:0] CODE_FLASH_REQ   = 3'b011;
  localparam logic [2:0] CODE_GO_NORMAL   = 3'b101;
  localparam logic [2:0] CODE_FLASH_LEAVE = 3'b110;
  localparam logic [2:0] CODE_FLASH_SERVE = 3'b111;

endpackage

// File: rtl/fsmc_rst_sync.sv
module fsmc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/fsmc_rst_pulse.sv
module fsmc_rst_pulse #(
  parameter int RST_LEN = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  output logic busy
);
  localparam int CW = $clog2(RST_LEN + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;

  always_comb begin
    cnt_en = start || (cnt_q != '0);
    cnt_d  = start ? CW'(RST_LEN) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);
endmodule

// File: rtl/fsmc_wdog.sv
module fsmc_wdog #(
  parameter int STARTUP_TICKS = 4096,
  parameter int FLASH_TICKS   = 8192
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic clr,
  input  logic sel_flash,
  output logic expired
);
  localparam int MAXT = (STARTUP_TICKS > FLASH_TICKS) ? STARTUP_TICKS : FLASH_TICKS;
  localparam int TW   = $clog2(MAXT + 1);
  localparam logic [TW-1:0] INIT_LAST  = TW'(STARTUP_TICKS - 1);
  localparam logic [TW-1:0] FLASH_LAST = TW'(FLASH_TICKS - 1);

  logic [TW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic [TW-1:0] last;

  always_comb begin
    last   = sel_flash ? FLASH_LAST : INIT_LAST;
    cnt_en = clr || run;
    cnt_d  = clr ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired = run && (cnt_q == last);
endmodule

// File: rtl/failsafe_mode_ctrl.sv
module failsafe_mode_ctrl
  import fsmc_pkg::*;
#(
  parameter int RST_LEN       = 16,
  parameter int STARTUP_TICKS = 4096,
  parameter int FLASH_TICKS   = 8192
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [2:0] wr_code,
  input  logic       osc_fail,
  input  logic       wake,
  output logic [1:0] mode,
  output logic       sys_rst,
  output logic [2:0] rst_src
);
  logic  rst_sn;
  mode_e mode_q, mode_d;
  src_e  src_q, src_d;
  logic  pend_q, pend_d;
  logic  fire, busy, wd_clr, wd_run, wd_exp;

  fsmc_rst_sync u_sync (.clk(clk), .rst_n(rst_n), .rst_sn(rst_sn));

  fsmc_rst_pulse #(.RST_LEN(RST_LEN)) u_pulse (
    .clk(clk), .rst_n(rst_sn), .start(fire), .busy(busy)
  );

  assign wd_run = ((mode_q == MD_STARTUP) || (mode_q == MD_FLASH)) && !busy;

  fsmc_wdog #(.STARTUP_TICKS(STARTUP_TICKS), .FLASH_TICKS(FLASH_TICKS)) u_wdog (
    .clk(clk), .rst_n(rst_sn), .run(wd_run), .clr(wd_clr),
    .sel_flash(mode_q == MD_FLASH), .expired(wd_exp)
  );

  // Next-state logic; priority: oscillator fail, fail-safe exit, pulse busy, write, timeout
  always_comb begin
    mode_d = mode_q;
    src_d  = src_q;
    pend_d = pend_q;
    fire   = 1'b0;
    wd_clr = 1'b0;
    if (osc_fail) begin
      if (mode_q != MD_FAILSAFE) begin
        mode_d = MD_FAILSAFE;
        src_d  = SRC_OSC;
        pend_d = 1'b0;
        wd_clr = 1'b1;
      end
    end else if (mode_q == MD_FAILSAFE) begin
      if (wake) begin
        mode_d = MD_STARTUP;
        src_d  = SRC_WAKE;
        fire   = 1'b1;
        wd_clr = 1'b1;
      end
    end else if (busy) begin
      wd_clr = 1'b1;
    end else if (wr_en) begin
      unique case (mode_q)
        MD_STARTUP: begin
          if (wr_code == CODE_FLASH_REQ) begin
            wd_clr = 1'b1;
            if (pend_q) begin
              mode_d = MD_FLASH;
              pend_d = 1'b0;
            end else begin
              pend_d = 1'b1;
              src_d  = SRC_HANDSHAKE;
              fire   = 1'b1;
            end
          end else if (wr_code == CODE_GO_NORMAL) begin
            mode_d = MD_NORMAL;
            pend_d = 1'b0;
            wd_clr = 1'b1;
          end else begin
            mode_d = MD_STARTUP;
            src_d  = SRC_ILLEGAL;
            pend_d = 1'b0;
            fire   = 1'b1;
            wd_clr = 1'b1;
          end
        end
        MD_NORMAL: begin
          if (wr_code != CODE_GO_NORMAL) begin
            mode_d = MD_STARTUP;
            src_d  = SRC_ILLEGAL;
            pend_d = 1'b0;
            fire   = 1'b1;
            wd_clr = 1'b1;
          end
        end
        MD_FLASH: begin
          wd_clr = 1'b1;
          if (wr_code == CODE_FLASH_LEAVE) begin
            mode_d = MD_STARTUP;
            src_d  = SRC_FLASH_EXIT;
            fire   = 1'b1;
          end else if (wr_code != CODE_FLASH_SERVE) begin
            mode_d = MD_STARTUP;
            src_d  = SRC_ILLEGAL;
            fire   = 1'b1;
          end
        end
        default: ;
      endcase
    end else if (wd_exp) begin
      src_d  = (mode_q == MD_FLASH) ? SRC_FLASH_TMO : SRC_INIT_TMO;
      mode_d = MD_STARTUP;
      pend_d = 1'b0;
      fire   = 1'b1;
      wd_clr = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      mode_q <= MD_STARTUP;
      src_q  <= SRC_POWERON;
      pend_q <= 1'b0;
    end else begin
      mode_q <= mode_d;
      src_q  <= src_d;
      pend_q <= pend_d;
    end
  end

  assign mode    = mode_q;
  assign rst_src = src_q;
  assign sys_rst = busy || (mode_q == MD_FAILSAFE);
endmodule

// File: rtl/failsafe_mode_ctrl_chk.sv
module failsafe_mode_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       osc_fail,
  input logic       wake,
  input logic [1:0] mode,
  input logic       sys_rst,
  input logic [2:0] rst_src
);
  assert_osc_to_failsafe_R10: assert property (@(posedge clk) disable iff (!rst_n)
    osc_fail |=> (mode == 2'b11));

  assert_failsafe_holds_reset_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b11) |-> sys_rst);

  assert_failsafe_exit_cond_R11: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode != 2'b11) && ($past(mode) == 2'b11)) |-> ($past(wake) && !$past(osc_fail)));

  assert_flash_from_startup_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ((mode == 2'b10) && ($past(mode) != 2'b10)) |-> ($past(mode) == 2'b00));

  assert_src_stable_in_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (sys_rst && (mode != 2'b11) && !osc_fail) |=> $stable(rst_src));

  assert_reset_lands_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sys_rst) |-> ((mode == 2'b00) || (mode == 2'b11)));
endmodule

bind failsafe_mode_ctrl failsafe_mode_ctrl_chk chk_i (
  .clk(clk), .rst_n(rst_sn), .osc_fail(osc_fail), .wake(wake),
  .mode(mode), .sys_rst(sys_rst), .rst_src(rst_src)
);

// File: tb/failsafe_mode_ctrl_tb_top.sv
module failsafe_mode_ctrl_tb_top;
  localparam int RST_LEN       = 4;
  localparam int STARTUP_TICKS = 40;
  localparam int FLASH_TICKS   = 30;

  logic       clk;
  logic       rst_n;
  logic       wr_en;
  logic [2:0] wr_code;
  logic       osc_fail;
  logic       wake;
  logic [1:0] mode;
  logic       sys_rst;
  logic [2:0] rst_src;

  int checks = 0;
  int errors = 0;
  int exp_src_q[$];
  string exp_tag_q[$];
  logic prev_rst = 1'b0;

  failsafe_mode_ctrl #(.RST_LEN(RST_LEN), .STARTUP_TICKS(STARTUP_TICKS),
                       .FLASH_TICKS(FLASH_TICKS)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_code(wr_code),
    .osc_fail(osc_fail), .wake(wake), .mode(mode), .sys_rst(sys_rst), .rst_src(rst_src)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic expect_reset(input int src, input string tag);
    exp_src_q.push_back(src);
    exp_tag_q.push_back(tag);
  endtask

  task automatic write_code(input logic [2:0] c);
    @(negedge clk); wr_en = 1'b1; wr_code = c;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (sys_rst) @(negedge clk);
  endtask

  // Monitor: every rising reset outside Fail-safe consumes one expected cause
  always @(negedge clk) begin
    if (rst_n) begin
      if (sys_rst && !prev_rst && mode != 2'b11) begin
        if (exp_src_q.size() == 0) begin
          check("R12 unexpected reset, src", int'(rst_src), 99);
        end else begin
          automatic int e = exp_src_q.pop_front();
          automatic string t = exp_tag_q.pop_front();
          check({t, " reset source"}, int'(rst_src), e);
          check({t, " lands in Start-up R12"}, int'(mode), 0);
        end
      end
    end
    prev_rst = sys_rst;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_code = 3'b000; osc_fail = 1'b0; wake = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 mode", int'(mode), 0);
    check("R1 sys_rst", int'(sys_rst), 0);
    check("R1 rst_src", int'(rst_src), 0);

    write_code(3'b101);
    check("R2 Start-up to Normal", int'(mode), 1);
    check("R2 no reset", int'(sys_rst), 0);
    write_code(3'b101);
    check("R2 Normal 101 no effect", int'(mode), 1);

    expect_reset(5, "R7 Normal illegal");
    write_code(3'b010);
    check("R7 back to Start-up", int'(mode), 0);
    for (int i = 0; i < RST_LEN - 1; i++) begin
      @(negedge clk);
      check("R9 pulse still high", int'(sys_rst), 1);
    end
    @(negedge clk);
    check("R9 pulse ends after RST_LEN", int'(sys_rst), 0);

    expect_reset(1, "R3 handshake");
    write_code(3'b011);
    check("R3 stays Start-up", int'(mode), 0);
    write_code(3'b101);
    wait_idle();
    check("R9 write in pulse ignored", int'(mode), 0);

    write_code(3'b011);
    check("R3 second request enters Flash", int'(mode), 2);
    check("R3 no reset on entry", int'(sys_rst), 0);

    for (int i = 0; i < 5; i++) begin
      repeat (18) @(negedge clk);
      write_code(3'b111);
    end
    check("R5 served Flash survives", int'(mode), 2);

    expect_reset(4, "R6 Flash exit");
    write_code(3'b110);
    check("R6 back to Start-up", int'(mode), 0);
    wait_idle();

    expect_reset(1, "R4 handshake");
    write_code(3'b011);
    wait_idle();
    write_code(3'b101);
    check("R4 101 enters Normal", int'(mode), 1);
    expect_reset(5, "R7 Normal illegal 000");
    write_code(3'b000);
    wait_idle();
    expect_reset(1, "R4 handshake restarts");
    write_code(3'b011);
    check("R4 not Flash after clear", int'(mode), 0);
    wait_idle();

    write_code(3'b011);
    check("R3 Flash entry", int'(mode), 2);
    expect_reset(3, "R5 Flash timeout");
    repeat (FLASH_TICKS + 2) @(negedge clk);
    wait_idle();
    check("R5 timeout to Start-up", int'(mode), 0);

    expect_reset(1, "R3 handshake again");
    write_code(3'b011);
    wait_idle();
    write_code(3'b011);
    check("R3 Flash entry again", int'(mode), 2);
    expect_reset(5, "R7 Flash illegal");
    write_code(3'b001);
    check("R7 Flash illegal to Start-up", int'(mode), 0);
    wait_idle();

    expect_reset(2, "R8 Start-up timeout");
    repeat (STARTUP_TICKS + 2) @(negedge clk);
    wait_idle();
    check("R8 stays Start-up", int'(mode), 0);

    osc_fail = 1'b1;
    @(negedge clk);
    check("R10 Fail-safe entered", int'(mode), 3);
    check("R10 source", int'(rst_src), 6);
    check("R10 reset held", int'(sys_rst), 1);
    write_code(3'b101);
    check("R10 write ignored", int'(mode), 3);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    @(negedge clk);
    check("R11 wake with bad osc ignored", int'(mode), 3);
    osc_fail = 1'b0;
    repeat (3) @(negedge clk);
    check("R11 good osc alone stays", int'(mode), 3);
    wake = 1'b1;
    @(negedge clk);
    wake = 1'b0;
    check("R11 exit to Start-up", int'(mode), 0);
    check("R11 source", int'(rst_src), 7);
    for (int i = 0; i < RST_LEN - 1; i++) begin
      @(negedge clk);
      check("R11 reset still high", int'(sys_rst), 1);
    end
    @(negedge clk);
    check("R11 reset released", int'(sys_rst), 0);

    write_code(3'b101);
    check("R2 Normal after recovery", int'(mode), 1);
    repeat (5) @(negedge clk);
    check("R12 all expected resets seen", exp_src_q.size(), 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule